// File: doc/BRIEF.md
# Selectable-Ratio CPU Phase Clock Generator

This block derives the CPU phase clock, M2, from one master oscillator. Static configuration inputs select a divide ratio of 12, 15 or 16 master clocks per CPU cycle and, for the ratio of 12, one of two duty profiles. The high time of M2 is an odd number of master half-cycles. The block therefore registers state on both master clock edges and combines it so that each M2 transition follows a single register change.

Two strobes, each one master cycle wide, go with M2. `cycle_start` marks the master cycle that opens each CPU cycle. `m2_rise` marks the master cycle during which M2 goes high. A synchronous reset holds the divider at the start of a cycle. A configuration change is applied only at the next cycle boundary, so M2 never shows a shortened pulse.

Top module: `phase_clk_gen`

## Requirements
- R1: `ratio_sel` picks the CPU cycle length N in master clocks: 0 gives 12, 1 gives 15, 2 gives 16, 3 gives 12. One M2 period spans 2N master half-cycles.
- R2: With N=12 and `alt_duty`=0, M2 is high for 15 and low for 9 master half-cycles in each period.
- R3: With N=12 and `alt_duty`=1, M2 is high for 17 and low for 7 master half-cycles.
- R4: With N=15, M2 is high for 17 and low for 13 master half-cycles, and `alt_duty` has no effect.
- R5: With N=16, M2 is high for 19 and low for 13 master half-cycles, and `alt_duty` has no effect.
- R6: M2 falls on the rising master edge that opens a CPU cycle (half-count 0). It rises on a falling master edge at half-count 2N−H, where H is the high time.
- R7: A change to `ratio_sel` or `alt_duty` made in the middle of a CPU cycle leaves the high time of that cycle unchanged. The new setting governs the cycle that follows.
- R8: While `rst` is sampled high, M2, `cycle_start` and `m2_rise` are low. After release, the first `cycle_start` is seen N master cycles after the first rising edge that samples `rst` low, counting that edge as the first.
- R9: `cycle_start` is high for exactly one master cycle per CPU cycle, in the cycle where M2 has just fallen, and M2 stays low while it is high.
- R10: `m2_rise` is high for the one master cycle in which M2 rises. M2 is low during the first half of that cycle and high during the second half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master oscillator; both edges are used |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | 2 | Divide ratio select (0:12, 1:15, 2:16, 3:12) |
| alt_duty | input | 1 | Selects the longer high time when the ratio is 12 |
| m2 | output | 1 | CPU phase clock |
| cycle_start | output | 1 | One-master-cycle strobe at the start of each CPU cycle |
| m2_rise | output | 1 | One-master-cycle strobe around the M2 rising edge |

## Verification
Every high and every low stretch of M2 is measured in half-cycles and compared with the expected value. A divider that counted on one edge only would be off by one half-cycle in every profile, and a wrong threshold would move the split between high and low. Settings are changed in the middle of a high phase: a design that applied them at once would cut that pulse short or stretch it. The bench counts the cycles from reset release to the first strobe for several ratios, which catches a divider that starts at the wrong phase. It also checks both strobes against M2 around each edge, which catches a strobe that is off by a cycle.

// File: rtl/phase_clk_gen.sv
module phase_clk_gen #(
  parameter int DIV_STD  = 12,
  parameter int HI_STD   = 15,
  parameter int HI_ALT   = 17,
  parameter int DIV_MID  = 15,
  parameter int HI_MID   = 17,
  parameter int DIV_LONG = 16,
  parameter int HI_LONG  = 19
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ratio_sel,
  input  logic       alt_duty,
  output logic       m2,
  output logic       cycle_start,
  output logic       m2_rise
);
  localparam int NMAX = (DIV_STD > DIV_MID) ? ((DIV_STD > DIV_LONG) ? DIV_STD : DIV_LONG)
                                            : ((DIV_MID > DIV_LONG) ? DIV_MID : DIV_LONG);
  localparam int CW = $clog2(NMAX);

  logic [CW-1:0] cnt, cnt_nx, last_q, rise_q, cfg_last, cfg_rise;
  logic wrap, arm_q, neg_q, cs_q, mr_q;

  always_comb begin
    case (ratio_sel)
      2'd1: begin
        cfg_last = CW'(DIV_MID - 1);
        cfg_rise = CW'(DIV_MID - (HI_MID + 1) / 2);
      end
      2'd2: begin
        cfg_last = CW'(DIV_LONG - 1);
        cfg_rise = CW'(DIV_LONG - (HI_LONG + 1) / 2);
      end
      default: begin
        cfg_last = CW'(DIV_STD - 1);
        cfg_rise = alt_duty ? CW'(DIV_STD - (HI_ALT + 1) / 2)
                            : CW'(DIV_STD - (HI_STD + 1) / 2);
      end
    endcase
  end

  assign wrap   = (cnt == last_q);
  assign cnt_nx = wrap ? '0 : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      last_q <= cfg_last;
      rise_q <= cfg_rise;
      arm_q  <= 1'b0;
      cs_q   <= 1'b0;
      mr_q   <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      arm_q <= !wrap && (cnt_nx >= rise_q);
      cs_q  <= wrap;
      mr_q  <= !wrap && (cnt_nx == rise_q);
      if (wrap) begin
        last_q <= cfg_last;
        rise_q <= cfg_rise;
      end
    end
  end

  always_ff @(negedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= arm_q;
  end

  assign m2          = arm_q & neg_q;
  assign cycle_start = cs_q;
  assign m2_rise     = mr_q;
endmodule

// File: rtl/phase_clk_gen_chk.sv
module phase_clk_gen_chk #(
  parameter int DIV_STD  = 12,
  parameter int DIV_MID  = 15,
  parameter int DIV_LONG = 16
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] ratio_sel,
  input logic       alt_duty,
  input logic       m2,
  input logic       cycle_start,
  input logic       m2_rise
);
  int gap;
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= 0;
      seen <= 1'b0;
    end else if (cycle_start) begin
      gap  <= 1;
      seen <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  p_quiet_in_reset_r8: assert property (@(posedge clk)
    rst |=> (!m2 && !cycle_start && !m2_rise));

  p_start_low_r9: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> !m2);

  p_start_single_r9: assert property (@(posedge clk) disable iff (rst)
    cycle_start |=> !cycle_start);

  p_fall_at_start_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cycle_start) |-> $past(m2));

  p_high_after_rise_r10: assert property (@(posedge clk) disable iff (rst)
    m2_rise |-> m2);

  p_rise_single_r10: assert property (@(posedge clk) disable iff (rst)
    m2_rise |=> !m2_rise);

  p_period_len_r1: assert property (@(posedge clk) disable iff (rst)
    (cycle_start && seen) |-> (gap == DIV_STD || gap == DIV_MID || gap == DIV_LONG));
endmodule

bind phase_clk_gen phase_clk_gen_chk u_chk (
  .clk(clk), .rst(rst), .ratio_sel(ratio_sel), .alt_duty(alt_duty),
  .m2(m2), .cycle_start(cycle_start), .m2_rise(m2_rise)
);

// File: tb/phase_clk_gen_test.sv
`timescale 1ns/1ps
module phase_clk_gen_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] ratio_sel = 2'd0;
  logic alt_duty = 1'b0;
  logic m2, cycle_start, m2_rise;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  logic mon_en = 1'b0;
  logic have_ref = 1'b0;
  realtime t_edge = 0;
  logic prev_cs = 1'b0;
  int cyc = 0;

  always #2 clk = ~clk;

  phase_clk_gen uut (
    .clk(clk), .rst(rst), .ratio_sel(ratio_sel), .alt_duty(alt_duty),
    .m2(m2), .cycle_start(cycle_start), .m2_rise(m2_rise)
  );

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int n_of(input logic [1:0] s);
    return (s == 2'd1) ? 15 : (s == 2'd2) ? 16 : 12;
  endfunction

  function automatic int hi_of(input logic [1:0] s, input logic a);
    if (s == 2'd1) return 17;
    if (s == 2'd2) return 19;
    return a ? 17 : 15;
  endfunction

  // monitor: items are duration*2 + (1 for high, 0 for low)
  always @(m2) begin
    if (!mon_en) begin
      have_ref = 1'b0;
    end else begin
      if (have_ref) begin
        int dur, item;
        dur = int'(($realtime - t_edge) / 2.0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R1-queue", dur, -1);
        end else begin
          item = exp_q.pop_front();
          check(item == dur * 2 + (m2 ? 0 : 1),
                m2 ? "R6 low time (R2/R3/R4/R5/R7)" : "R6 high time (R2/R3/R4/R5/R7)",
                dur, item / 2);
        end
      end else if (!m2) begin
        t_edge = $realtime;
      end
      if (m2 || have_ref) begin
        have_ref = 1'b1;
        t_edge = $realtime;
      end
    end
  end

  // strobe sampler, away from the rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (!rst && cycle_start) begin
      check(m2 == 1'b0, "R9 m2 low with cycle_start", m2, 0);
      check(prev_cs == 1'b0, "R9 cycle_start one cycle", prev_cs, 0);
    end
    prev_cs = cycle_start;
    if (!rst && m2_rise) begin
      check(m2 == 1'b0, "R10 m2 low in first half", m2, 0);
      #2;
      check(m2 == 1'b1, "R10 m2 high in second half", m2, 1);
    end
  end

  task automatic push_pair(input int hi, input int n);
    exp_q.push_back(hi * 2 + 1);
    exp_q.push_back((2 * n - hi) * 2);
  endtask

  task automatic wait_empty();
    int t = 0;
    while (exp_q.size() != 0 && t < 3000) begin
      @(posedge clk);
      t++;
    end
    check(exp_q.size() == 0, "R1 periods seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic start(input logic [1:0] s, input logic a, input int periods);
    int i;
    @(posedge clk); #1;
    mon_en = 1'b0;
    rst = 1'b1;
    ratio_sel = s;
    alt_duty = a;
    repeat (3) begin
      @(posedge clk); #1;
      check(!m2 && !cycle_start && !m2_rise, "R8 outputs low in reset",
            {m2, cycle_start, m2_rise}, 0);
    end
    for (int p = 0; p < periods; p++) push_pair(hi_of(s, a), n_of(s));
    mon_en = 1'b1;
    rst = 1'b0;
    i = 0;
    while (i < 40) begin
      @(posedge clk); #1;
      i++;
      if (cycle_start) break;
    end
    check(i == n_of(s), "R8 first cycle_start after release", i, n_of(s));
    wait_empty();
  endtask

  // called right after an M2 rise: the current high phase still follows the old setting
  task automatic switch_to(input logic [1:0] s, input logic a, input int old_hi, input int periods);
    #1;
    exp_q.push_back(old_hi * 2 + 1);
    ratio_sel = s;
    alt_duty = a;
    exp_q.push_back((2 * n_of(s) - hi_of(s, a)) * 2);
    for (int p = 1; p < periods; p++) push_pair(hi_of(s, a), n_of(s));
    wait_empty();
  endtask

  initial begin
    start(2'd0, 1'b0, 4);             // R2
    switch_to(2'd0, 1'b1, 15, 4);     // R3, R7
    switch_to(2'd1, 1'b0, 17, 4);     // R4, R7
    switch_to(2'd1, 1'b1, 17, 3);     // R4 alt ignored
    switch_to(2'd2, 1'b0, 17, 4);     // R5
    switch_to(2'd2, 1'b1, 19, 3);     // R5 alt ignored
    switch_to(2'd3, 1'b0, 19, 3);     // R1 code 3
    switch_to(2'd0, 1'b0, 15, 2);     // R2 back
    start(2'd2, 1'b0, 3);             // R8 with 16
    start(2'd1, 1'b1, 3);             // R8 with 15
    start(2'd3, 1'b1, 3);             // R1, R3 with code 3
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule